// File: doc/BRIEF.md
# Derived Digital Channel Generator

This block turns a stream of sampled analog values into two logic-level channels. The first channel comes from comparing each valid sample against a threshold that a processor writes. That threshold stands for the measured mean of the signal, so the first channel follows the input at the same frequency and phase. A hysteresis band around the threshold, also programmable, keeps noise near the crossing point from toggling the output.

The second channel is built by counting valid sample ticks from each rising edge of the first channel. The block measures the distance between successive rising edges in valid ticks, which gives the period. It then drives the second channel high after one eighth of that period, for one quarter of that period. The result is a pulse that lags the first channel by 45 degrees and has a 25% duty cycle. Only the comparison and the timing are done here. The mean value is computed elsewhere, and the block does no display work.

Top module: `dchan_gen`

## Requirements
- R1: With `chan_a` low, a valid sample raises `chan_a` when the sample is strictly greater than `thr_level + hyst_band`. A sample equal to that sum leaves it low.
- R2: With `chan_a` high, a valid sample drops `chan_a` when `smp_data + hyst_band <= thr_level`. Otherwise `chan_a` stays high. With `hyst_band` zero, `chan_a` is high exactly when the sample exceeds `thr_level`.
- R3: Both outputs are registered and change only on the clock edge that takes a valid sample, so they appear one cycle after that sample. Cycles with `smp_valid` low leave both outputs unchanged, whatever `smp_data` holds.
- R4: The period P is the number of valid ticks from one rising-edge tick of `chan_a` to the next, counting the later tick but not the earlier one. P is refreshed on every rising edge after the first.
- R5: `chan_b` stays low until two rising edges of `chan_a` have been seen since reset.
- R6: Let k be the number of valid ticks since the latest rising-edge tick, with k = 0 on that tick. Once locked, `chan_b` goes high at k = P>>3.
- R7: `chan_b` stays high while k < (P>>3) + (P>>2), which is P>>2 valid ticks. When P < 4, `chan_b` does not go high.
- R8: Every rising edge of `chan_a` restarts k at zero and applies the period just measured, so the timing of `chan_b` follows a change of input period from the next edge onward.
- R9: While `rst` is high, both outputs are low and the count of edges seen is cleared.
- R10: The threshold arithmetic is one bit wider than the sample, so it cannot wrap. If `thr_level + hyst_band` is at or above the largest sample value, `chan_a` cannot rise. If `hyst_band > thr_level`, a high `chan_a` cannot fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one valid tick per high cycle |
| smp_data | input | SAMPLE_W | Unsigned sample value |
| thr_level | input | SAMPLE_W | Threshold written by the processor (signal mean) |
| hyst_band | input | SAMPLE_W | Half-width of the hysteresis band |
| chan_a | output | 1 | Threshold-derived channel |
| chan_b | output | 1 | Delayed quarter-duty channel locked to chan_a |

## Verification
The assertions assume that `thr_level` and `hyst_band` stay steady while a waveform runs. They also assume that the period stays well below the saturation limit of the tick counters. Because of that limit, a locked period is never zero, and the phase counter is at zero right after a rising edge. The stimulus changes the threshold and band only between directed segments and uses periods of at most 96 ticks. Random gaps in `smp_valid` and noise samples inside the band test whether idle cycles and in-band values leave the outputs alone.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    // Channel B timing as right shifts of the measured period
    localparam int DLY_SHIFT = 3;   // 1/8 period -> 45 degrees
    localparam int WID_SHIFT = 2;   // 1/4 period -> 25 % duty

    // Lock progress of the period meter
    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_ONE    = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_t;

    // Comparator result for the current tick
    typedef struct packed {
        logic level;   // chan_a value after this cycle
        logic rise;    // valid tick on which chan_a goes 0 -> 1
    } cmp_t;

endpackage

// File: rtl/dcg_level_cmp.sv
module dcg_level_cmp
    import dcg_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [SAMPLE_W-1:0] thr,
    input  logic [SAMPLE_W-1:0] hyst,
    output cmp_t                nxt,
    output logic                a_q
);
    localparam int EW = SAMPLE_W + 1;

    logic [EW-1:0] smp_w;
    logic [EW-1:0] thr_w;
    logic [EW-1:0] up_lim;
    logic [EW-1:0] smp_plus_h;
    logic          lvl;

    always_comb begin
        smp_w      = {1'b0, smp};
        thr_w      = {1'b0, thr};
        up_lim     = thr_w + {1'b0, hyst};
        smp_plus_h = smp_w + {1'b0, hyst};
        if (a_q) lvl = !(smp_plus_h <= thr_w);
        else     lvl = (smp_w > up_lim);
        nxt.level = smp_valid ? lvl : a_q;
        nxt.rise  = smp_valid & lvl & ~a_q;
    end

    always_ff @(posedge clk) begin
        if (rst) a_q <= 1'b0;
        else     a_q <= nxt.level;
    end

    assert_a_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(a_q));

    assert_a_rise_above_R1: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !a_q && (smp_w > up_lim)) |=> a_q);

endmodule

// File: rtl/dcg_period_meter.sv
module dcg_period_meter
    import dcg_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rise,
    output logic [PERIOD_W-1:0] per_nxt,
    output logic                lock_nxt,
    output logic [PERIOD_W-1:0] per_q,
    output logic                lock_q
);
    localparam logic [PERIOD_W-1:0] CNT_MAX = {PERIOD_W{1'b1}};

    lock_state_t         st_q, st_n;
    logic [PERIOD_W-1:0] cnt_q, cnt_n, cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        st_n    = st_q;
        cnt_n   = cnt_q;
        per_nxt = per_q;
        if (tick) begin
            if (rise) begin
                cnt_n = '0;
                if (st_q == LK_IDLE) begin
                    st_n = LK_ONE;
                end else begin
                    st_n    = LK_LOCKED;
                    per_nxt = cnt_inc;
                end
            end else begin
                cnt_n = cnt_inc;
            end
        end
        lock_nxt = (st_n == LK_LOCKED);
        lock_q   = (st_q == LK_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_IDLE;
            cnt_q <= '0;
            per_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            per_q <= per_nxt;
        end
    end

    assert_period_live_R4: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> (per_q != '0));

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

endmodule

// File: rtl/dcg_burst_gen.sv
module dcg_burst_gen
    import dcg_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rise,
    input  logic [PERIOD_W-1:0] per,
    input  logic                lock,
    output logic                b_q
);
    localparam logic [PERIOD_W-1:0] PH_MAX = {PERIOD_W{1'b1}};

    logic [PERIOD_W-1:0] ph_q, ph_n;
    logic [PERIOD_W-1:0] dly, wid, stop;
    logic                b_n;

    always_comb begin
        dly  = per >> DLY_SHIFT;
        wid  = per >> WID_SHIFT;
        stop = dly + wid;
        if (rise)                ph_n = '0;
        else if (ph_q == PH_MAX) ph_n = ph_q;
        else                     ph_n = ph_q + 1'b1;
        b_n = lock && (ph_n >= dly) && (ph_n < stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
            b_q  <= 1'b0;
        end else if (tick) begin
            ph_q <= ph_n;
            b_q  <= b_n;
        end
    end

    assert_phase_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && rise) |=> (ph_q == '0));

    assert_b_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(b_q));

endmodule

// File: rtl/dchan_gen.sv
module dchan_gen
    import dcg_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] thr_level,
    input  logic [SAMPLE_W-1:0] hyst_band,
    output logic                chan_a,
    output logic                chan_b
);
    cmp_t                cmp;
    logic [PERIOD_W-1:0] per_nxt, per_q;
    logic                lock_nxt, lock_q;

    dcg_level_cmp #(.SAMPLE_W(SAMPLE_W)) cmp_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp       (smp_data),
        .thr       (thr_level),
        .hyst      (hyst_band),
        .nxt       (cmp),
        .a_q       (chan_a)
    );

    dcg_period_meter #(.PERIOD_W(PERIOD_W)) meter_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (smp_valid),
        .rise     (cmp.rise),
        .per_nxt  (per_nxt),
        .lock_nxt (lock_nxt),
        .per_q    (per_q),
        .lock_q   (lock_q)
    );

    dcg_burst_gen #(.PERIOD_W(PERIOD_W)) burst_i (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_valid),
        .rise (cmp.rise),
        .per  (per_nxt),
        .lock (lock_nxt),
        .b_q  (chan_b)
    );

    assert_b_needs_lock_R5: assert property (@(posedge clk) disable iff (rst)
        chan_b |-> lock_q);

    assert_b_window_R7: assert property (@(posedge clk) disable iff (rst)
        chan_b |-> (per_q >= PERIOD_W'(4)));

endmodule

// File: tb/dchan_gen_tb_top.sv
module dchan_gen_tb_top;
    localparam int SW   = 12;
    localparam int PW   = 16;
    localparam int PMAX = (1 << PW) - 1;
    localparam int SMAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-1:0] thr_level = '0;
    logic [SW-1:0] hyst_band = '0;
    logic          chan_a, chan_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    int m_a, m_cnt, m_per, m_rises, m_ph, m_b;

    always #5 clk = ~clk;

    dchan_gen #(.SAMPLE_W(SW), .PERIOD_W(PW)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_level(thr_level), .hyst_band(hyst_band),
        .chan_a(chan_a), .chan_b(chan_b)
    );

    task automatic model_reset();
        m_a = 0; m_cnt = 0; m_per = 0; m_rises = 0; m_ph = 0; m_b = 0;
    endtask

    task automatic model_tick(int s);
        int t, h, an, rise, inc, d, w;
        t = int'(thr_level);
        h = int'(hyst_band);
        if (m_a != 0) an = ((s + h) <= t) ? 0 : 1;
        else          an = (s > t + h) ? 1 : 0;
        rise = (an == 1 && m_a == 0) ? 1 : 0;
        inc  = (m_cnt == PMAX) ? PMAX : m_cnt + 1;
        if (rise != 0) begin
            if (m_rises >= 1) m_per = inc;
            if (m_rises < 2) m_rises++;
            m_cnt = 0;
            m_ph  = 0;
        end else begin
            m_cnt = inc;
            m_ph  = (m_ph == PMAX) ? PMAX : m_ph + 1;
        end
        m_a = an;
        d = m_per >> 3;
        w = m_per >> 2;
        m_b = (m_rises == 2 && m_ph >= d && m_ph < d + w) ? 1 : 0;
    endtask

    task automatic chk(string tag, string nm, logic act, int exp);
        n_chk++;
        if (act !== exp[0]) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp[0], $time);
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, compare
    task automatic step(bit v, int s, string tag);
        smp_valid = v;
        smp_data  = s[SW-1:0];
        if (v) model_tick(s);
        @(negedge clk);
        chk(tag, "chan_a", chan_a, m_a);
        chk(tag, "chan_b", chan_b, m_b);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b1;
        smp_data  = SW'(SMAX);
        repeat (3) @(negedge clk);
        chk("R9", "chan_a", chan_a, 0);
        chk("R9", "chan_b", chan_b, 0);
        rst = 1'b0;
        smp_valid = 1'b0;
        model_reset();
    endtask

    function automatic int clip(int x);
        if (x < 0) return 0;
        if (x > SMAX) return SMAX;
        return x;
    endfunction

    // square-like wave of per valid ticks, optional idle gaps and in-band noise
    task automatic wave(int per, int cycles, int gap_pct, bit noise, string tag);
        int t, h, s;
        t = int'(thr_level);
        h = int'(hyst_band);
        for (int i = 0; i < per * cycles; i++) begin
            while (int'($urandom % 100) < gap_pct)
                step(0, int'($urandom % (SMAX + 1)), "R3");
            if ((i % per) < per / 2) s = clip(t + h + 1 + int'($urandom % 300));
            else                     s = clip(t - h - int'($urandom % 300));
            if (noise && h > 0 && ($urandom % 4) == 0)
                s = t - h + 1 + int'($urandom % (2 * h));
            step(1, s, tag);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int r;
        r = int'($urandom(32'h5eed_0042));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1 / R2: hysteresis edges
        thr_level = 12'd2000; hyst_band = 12'd50;
        step(1, 2050, "R1");
        step(1, 2051, "R1");
        step(1, 1951, "R2");
        step(1, 1950, "R2");
        hyst_band = 12'd0;
        step(1, 2000, "R2");
        step(1, 2001, "R1");
        step(1, 2000, "R2");
        // R3: idle cycles with wild data
        step(0, SMAX, "R3");
        step(0, 0, "R3");

        // R10: no wrap of limits
        thr_level = 12'd4000; hyst_band = 12'd200;
        step(1, SMAX, "R10");
        thr_level = 12'd100; hyst_band = 12'd0;
        step(1, SMAX, "R10");
        hyst_band = 12'd200;
        step(1, 0, "R10");
        step(1, 0, "R10");

        // locking sequence from a clean reset
        do_reset();
        thr_level = 12'd2048; hyst_band = 12'd0;
        step(1, 0, "R5");
        wave(16, 1, 0, 0, "R5");
        wave(16, 4, 0, 0, "R6");
        wave(40, 3, 0, 0, "R7");
        wave(24, 3, 30, 0, "R4");
        wave(3, 4, 0, 0, "R7");
        wave(64, 2, 0, 0, "R8");
        wave(16, 3, 0, 0, "R8");

        // random segments with hysteresis and noise
        hyst_band = 12'd120;
        for (int seg = 0; seg < 24; seg++) begin
            hyst_band = SW'($urandom % 200);
            wave(8 + int'($urandom % 89), 2 + int'($urandom % 3),
                 int'($urandom % 50), 1, "R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule